// File: doc/BRIEF.md
# Byte-Lane Misaligned Access Splitter

This block sits between a processor core and a bus cycle sequencer. Memory behind it is byte addressed and built as two 8-bit banks on a 16-bit data bus: the even bank sits on the low data lane (bits 7..0) and is enabled when the address LSB is low. The odd bank sits on the high lane (bits 15..8) and is enabled when the active-low high-lane enable is low. The core issues byte or word reads and writes at any 20-bit address. The splitter turns each request into one or two bus transactions. Each transaction carries a word address (address bits 19..1), the address LSB and the high-lane enable. The splitter moves write bytes onto the lanes the banks expect, and it puts read bytes back into their result positions.

A word at an odd address spans two bank rows, so it is split into two ordered bus transactions. The first transaction carries the low-order byte on the high lane. The second carries the high-order byte on the low lane at the next, wrapped, address. For a split read, the first byte is held in a register until the second transaction ends. The whole word is then returned with a single completion pulse.

The sequencer handshake is a level `bus_valid` that is held with stable fields until the sequencer answers with `bus_ack`. Read data is taken in the acknowledge cycle. New requests are taken only while the splitter is idle.

Top module: `bytelane_splitter`

## Requirements
- R1: A byte access at an even address makes one transaction with word address = addr>>1, `bus_a0`=0 and `bus_bhe_n`=1. Write data byte wdata[7:0] goes on bus bits 7..0 and bits 15..8 are driven 0. The read result is {8'h00, bus bits 7..0}.
- R2: A byte access at an odd address makes one transaction with word address = addr>>1, `bus_a0`=1 and `bus_bhe_n`=0. Write byte wdata[7:0] goes on bus bits 15..8 and bits 7..0 are 0. The read result is {8'h00, bus bits 15..8}.
- R3: A word access at an even address makes one transaction with `bus_a0`=0 and `bus_bhe_n`=0. wdata is placed unchanged (low byte on bits 7..0), and the read result equals the bus data.
- R4: The first transaction of an odd-address word goes to word address addr>>1 with `bus_a0`=1 and `bus_bhe_n`=0. It carries wdata[7:0] on bits 15..8, with bits 7..0 driven 0.
- R5: The second transaction of an odd-address word follows directly after the first acknowledge. It goes to word address ((addr+1) mod 2^20)>>1 with `bus_a0`=0 and `bus_bhe_n`=1. It carries wdata[15:8] on bits 7..0, with bits 15..8 driven 0. An access at 0xFFFFF wraps to word address 0.
- R6: A split word read returns {second-transaction bits 7..0, first-transaction bits 15..8} with one `done` pulse, and only after the second acknowledge.
- R7: `bus_valid` rises in the cycle after a request is accepted. Its fields stay stable until a cycle with `bus_ack` high. `done` is a one-cycle pulse in the cycle after the final acknowledge, and in that cycle `bus_valid` is low and `rdata` holds the read result.
- R8: `busy` is high from the cycle after acceptance until the final acknowledge, across both halves of a split access. A `req_valid` presented while busy is ignored and starts no transaction.
- R9: While `rst` is high at a clock edge, `busy`, `bus_valid` and `done` are cleared after that edge, including in the middle of a split access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte uses bits 7..0) |
| busy | output | 1 | Access in progress |
| bus_valid | output | 1 | Transaction pending to the sequencer |
| bus_write | output | 1 | Transaction direction |
| bus_waddr | output | 19 | Word address (address bits 19..1) |
| bus_a0 | output | 1 | Address LSB, low enables the even bank |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_ack | input | 1 | Sequencer completes the pending transaction |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Reassembled read result |

## Verification
The hardest situation to reach from the ports is an odd-address word at the very top of the address space. There the second transaction must wrap to word address zero while the first byte is still held, and all of this happens with stalls and a competing request arriving mid-access. The bench sweeps the lowest and highest 32 byte addresses in every size and direction. It uses 0 to 2 stall cycles per transaction and injects an extra request during some stalled first halves. Bus read data is a function of the word address, so every lane and every reassembled result has a known, distinct value.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bls_cycle_plan.sv
module bls_cycle_plan #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                word,
  input  logic [2*LANE_W-1:0] wdata,
  output logic                split,
  output logic [ADDR_W-2:0]   c1_waddr,
  output logic                c1_a0,
  output logic                c1_bhe_n,
  output logic [2*LANE_W-1:0] c1_wdata,
  output logic [ADDR_W-2:0]   c2_waddr,
  output logic [2*LANE_W-1:0] c2_wdata
);
  localparam logic [ADDR_W-2:0] WA_ONE = {{(ADDR_W-2){1'b0}}, 1'b1};
  localparam logic [LANE_W-1:0] LANE_ZERO = '0;

  logic              odd;
  logic [LANE_W-1:0] lo_byte;
  logic [LANE_W-1:0] hi_byte;

  always_comb begin
    odd      = addr[0];
    lo_byte  = wdata[LANE_W-1:0];
    hi_byte  = wdata[2*LANE_W-1:LANE_W];
    split    = word & odd;
    c1_waddr = addr[ADDR_W-1:1];
    c1_a0    = odd;
    c1_bhe_n = ~(odd | word);
    if (odd)       c1_wdata = {lo_byte, LANE_ZERO};
    else if (word) c1_wdata = wdata;
    else           c1_wdata = {LANE_ZERO, lo_byte};
    // second half targets the next byte; the word address wraps with its width
    c2_waddr = addr[ADDR_W-1:1] + WA_ONE;
    c2_wdata = {LANE_ZERO, hi_byte};
  end
endmodule

// File: rtl/bls_read_merge.sv
module bls_read_merge #(
  parameter int LANE_W = 8
) (
  input  logic                odd,
  input  logic                word,
  input  logic                second,
  input  logic [2*LANE_W-1:0] bus_rdata,
  input  logic [LANE_W-1:0]   held_lo,
  output logic [2*LANE_W-1:0] result
);
  localparam logic [LANE_W-1:0] LANE_ZERO = '0;

  always_comb begin
    if (second)    result = {bus_rdata[LANE_W-1:0], held_lo};
    else if (word) result = bus_rdata;
    else if (odd)  result = {LANE_ZERO, bus_rdata[2*LANE_W-1:LANE_W]};
    else           result = {LANE_ZERO, bus_rdata[LANE_W-1:0]};
  end
endmodule

// File: rtl/bytelane_splitter.sv
module bytelane_splitter #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                busy,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [ADDR_W-2:0]   bus_waddr,
  output logic                bus_a0,
  output logic                bus_bhe_n,
  output logic [2*LANE_W-1:0] bus_wdata,
  input  logic                bus_ack,
  input  logic [2*LANE_W-1:0] bus_rdata,
  output logic                done,
  output logic [2*LANE_W-1:0] rdata
);
  import bls_pkg::*;

  localparam int DW = 2 * LANE_W;

  seq_state_t        state;
  logic              split_q;
  logic              odd_q;
  logic              word_q;
  logic [ADDR_W-2:0] c2_waddr_q;
  logic [DW-1:0]     c2_wdata_q;
  logic [LANE_W-1:0] held_lo;

  logic              p_split;
  logic [ADDR_W-2:0] p_c1_waddr;
  logic              p_c1_a0;
  logic              p_c1_bhe_n;
  logic [DW-1:0]     p_c1_wdata;
  logic [ADDR_W-2:0] p_c2_waddr;
  logic [DW-1:0]     p_c2_wdata;
  logic [DW-1:0]     merged;
  logic              accept;
  logic              finish;

  bls_cycle_plan #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) plan_i (
    .addr     (req_addr),
    .word     (req_word),
    .wdata    (req_wdata),
    .split    (p_split),
    .c1_waddr (p_c1_waddr),
    .c1_a0    (p_c1_a0),
    .c1_bhe_n (p_c1_bhe_n),
    .c1_wdata (p_c1_wdata),
    .c2_waddr (p_c2_waddr),
    .c2_wdata (p_c2_wdata)
  );

  bls_read_merge #(.LANE_W(LANE_W)) merge_i (
    .odd       (odd_q),
    .word      (word_q),
    .second    (state == ST_SECOND),
    .bus_rdata (bus_rdata),
    .held_lo   (held_lo),
    .result    (merged)
  );

  assign accept = req_valid && (state == ST_IDLE);
  assign finish = bus_ack && (((state == ST_FIRST) && !split_q) || (state == ST_SECOND));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      bus_valid  <= 1'b0;
      bus_write  <= 1'b0;
      bus_waddr  <= '0;
      bus_a0     <= 1'b0;
      bus_bhe_n  <= 1'b1;
      bus_wdata  <= '0;
      done       <= 1'b0;
      rdata      <= '0;
      split_q    <= 1'b0;
      odd_q      <= 1'b0;
      word_q     <= 1'b0;
      c2_waddr_q <= '0;
      c2_wdata_q <= '0;
      held_lo    <= '0;
    end else begin
      done <= 1'b0;
      if (finish) begin
        state     <= ST_IDLE;
        busy      <= 1'b0;
        bus_valid <= 1'b0;
        done      <= 1'b1;
        if (!bus_write) rdata <= merged;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (accept) begin
              state      <= ST_FIRST;
              busy       <= 1'b1;
              bus_valid  <= 1'b1;
              bus_write  <= req_write;
              bus_waddr  <= p_c1_waddr;
              bus_a0     <= p_c1_a0;
              bus_bhe_n  <= p_c1_bhe_n;
              bus_wdata  <= p_c1_wdata;
              split_q    <= p_split;
              odd_q      <= req_addr[0];
              word_q     <= req_word;
              c2_waddr_q <= p_c2_waddr;
              c2_wdata_q <= p_c2_wdata;
            end
          end
          ST_FIRST: begin
            if (bus_ack) begin
              state     <= ST_SECOND;
              bus_waddr <= c2_waddr_q;
              bus_a0    <= 1'b0;
              bus_bhe_n <= 1'b1;
              bus_wdata <= c2_wdata_q;
              held_lo   <= bus_rdata[DW-1:LANE_W];
            end
          end
          ST_SECOND: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bytelane_splitter_chk.sv
module bytelane_splitter_chk #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                bus_valid,
  input logic                bus_ack,
  input logic                bus_write,
  input logic [ADDR_W-2:0]   bus_waddr,
  input logic                bus_a0,
  input logic                bus_bhe_n,
  input logic [2*LANE_W-1:0] bus_wdata,
  input logic                done
);
  assert_bank_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !(bus_a0 && bus_bhe_n));

  assert_hold_fields_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_waddr) && $stable(bus_a0)
      && $stable(bus_bhe_n) && $stable(bus_wdata) && $stable(bus_write)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_valid && !busy));

  assert_second_half_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ack) |=> (bus_valid -> (!bus_a0 && bus_bhe_n)));

  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_valid && bus_ack));

  assert_valid_busy_R8: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> busy);

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!busy && !bus_valid && !done));
endmodule

bind bytelane_splitter bytelane_splitter_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .bus_valid (bus_valid),
  .bus_ack   (bus_ack),
  .bus_write (bus_write),
  .bus_waddr (bus_waddr),
  .bus_a0    (bus_a0),
  .bus_bhe_n (bus_bhe_n),
  .bus_wdata (bus_wdata),
  .done      (done)
);

// File: tb/bytelane_splitter_tb_top.sv
module bytelane_splitter_tb_top;
  localparam int AW = 20;
  localparam int LW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, bus_valid, bus_write, bus_a0, bus_bhe_n, done;
  logic [AW-2:0] bus_waddr;
  logic [DW-1:0] bus_wdata, bus_rdata, rdata;
  logic          bus_ack = 1'b0;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 0;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  assign bus_rdata = {pat({bus_waddr, 1'b1}), pat({bus_waddr, 1'b0})};

  bytelane_splitter #(.ADDR_W(AW), .LANE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_waddr(bus_waddr), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input bit wr, input bit wd, input logic [AW-1:0] a,
                        input logic [DW-1:0] wdat, input int waits, input bit poke);
    int            ncyc;
    logic [AW-2:0] ew;
    logic          ea0, ebhe;
    logic [DW-1:0] ewd, eres;
    string         tg;
    logic [AW-1:0] a1;
    a1 = a + 20'd1;
    ncyc = (wd && a[0]) ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < ncyc; c++) begin
      if (!wd && !a[0])     begin tg = "R1"; ew = a[AW-1:1]; ea0 = 0; ebhe = 1; ewd = {8'h00, wdat[7:0]}; end
      else if (!wd)         begin tg = "R2"; ew = a[AW-1:1]; ea0 = 1; ebhe = 0; ewd = {wdat[7:0], 8'h00}; end
      else if (!a[0])       begin tg = "R3"; ew = a[AW-1:1]; ea0 = 0; ebhe = 0; ewd = wdat; end
      else if (c == 0)      begin tg = "R4"; ew = a[AW-1:1]; ea0 = 1; ebhe = 0; ewd = {wdat[7:0], 8'h00}; end
      else                  begin tg = "R5"; ew = a1[AW-1:1]; ea0 = 0; ebhe = 1; ewd = {8'h00, wdat[15:8]}; end
      chk({"R7 bus_valid up ", tg}, 32'(bus_valid), 32'd1);
      chk("R8 busy during access", 32'(busy), 32'd1);
      chk({tg, " word address"}, 32'(bus_waddr), 32'(ew));
      chk({tg, " a0"}, 32'(bus_a0), 32'(ea0));
      chk({tg, " bhe_n"}, 32'(bus_bhe_n), 32'(ebhe));
      chk({tg, " direction"}, 32'(bus_write), 32'(wr));
      if (wr) chk({tg, " lane data"}, 32'(bus_wdata), 32'(ewd));
      for (int w = 0; w < waits; w++) begin
        if (poke && c == 0 && w == 0) begin
          req_valid = 1'b1; req_word = 1'b0; req_addr = a ^ 20'h2;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 hold valid", 32'(bus_valid), 32'd1);
        chk("R7 hold address", 32'(bus_waddr), 32'(ew));
        chk("R7 hold a0", 32'(bus_a0), 32'(ea0));
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
    chk("R7 done pulse", 32'(done), 32'd1);
    chk("R8 busy clear at end", 32'(busy), 32'd0);
    chk("R7 valid clear at end", 32'(bus_valid), 32'd0);
    if (!wr) begin
      if (wd) eres = {pat(a1), pat(a)};
      else    eres = {8'h00, pat(a)};
      if (!wd)        tg = a[0] ? "R2 read" : "R1 read";
      else if (a[0])  tg = "R6 split read";
      else            tg = "R3 read";
      chk(tg, 32'(rdata), 32'(eres));
    end
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 32'd0);
    chk("R8 ignored request starts nothing", 32'(bus_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", 32'(busy), 32'd0);
    chk("R9 reset valid", 32'(bus_valid), 32'd0);
    chk("R9 reset done", 32'(done), 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [AW-1:0] a;
          int            wt;
          a  = (i < 32) ? AW'(i) : (20'hFFFE0 + AW'(i - 32));
          wt = (i + wd + wr) % 3;
          do_txn(wr[0], wd[0], a, {pat(a + 20'h3), pat(a + 20'h9)}, wt,
                 (wt != 0) && (i % 4 == 0));
        end
      end
    end
    do_txn(1'b0, 1'b1, 20'h20005, 16'h0, 1, 1'b0);
    // R9: reset in the middle of a split access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 20'h00013;
    @(negedge clk);
    req_valid = 1'b0;
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    chk("R9 split in second half", 32'(bus_a0), 32'd0);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid-access reset busy", 32'(busy), 32'd0);
    chk("R9 mid-access reset valid", 32'(bus_valid), 32'd0);
    rst = 1'b0;
    do_txn(1'b0, 1'b0, 20'h00007, 16'h0, 0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule